// File: doc/BRIEF.md
# Pad Function and Drive Configuration Register Bank

This block stores the configuration of a bank of 32 pads and sends it to the pad ring as flat per-pin vectors. Each pad has three settings. A 2-bit function code picks which peripheral drives the pad, and one code value means plain GPIO. A drive field holds a 2-bit strength code and a voltage-select bit. A single bit turns the pull-up on.

Software reaches the registers over a simple single-cycle memory-mapped bus. Each register has three addresses:

- a plain address, where a write replaces the stored value;
- a set alias, where each 1 in the written word turns the matching stored bit on;
- a clear alias, where each 1 in the written word turns the matching stored bit off.

A packed multi-bit field can therefore be rewritten without a read-modify-write. Software first writes the field's mask to the clear alias, then writes the new value to the set alias. Pins that share the same word are not touched.

Top module: `padcfg_regs`

## Requirements
- R1: After reset, every function field holds the GPIO code 3 (function words read 0xFFFFFFFF). All drive words and the pull-up word read 0, and `bus_rdata` is 0.
- R2: The address decodes as follows. `bus_addr[7:4]` is the register index, `bus_addr[3:2]` is the view and `bus_addr[1:0]` is ignored. Indices 0 and 1 are the function words, indices 2 to 5 are the drive words and index 6 is the pull-up word. View 0 is plain, view 1 is set and view 2 is clear. A write to view 0 replaces the register with the written word (reserved bits excepted) at the next clock edge.
- R3: A write to view 1 ORs the written ones into the register. Every other bit keeps its value.
- R4: A write to view 2 clears each bit that is written as 1. Every other bit keeps its value.
- R5: A clear of a field mask followed by a set of a new value changes only that field. All other fields in the same word are unchanged.
- R6: Pin n takes its function from word n/16, bits [2*(n%16)+1 : 2*(n%16)], and drives it on `pin_func[2n+1:2n]`.
- R7: Pin n takes its drive settings from drive word n/8, nibble n%8. Nibble bits [1:0] are the strength, which goes out on `pin_strength[2n+1:2n]`. Nibble bit 2 is the voltage select, which goes out on `pin_hv[n]`: 1 selects the higher rail and 0 selects 1.8 V. Nibble bit 3 is reserved: it is not stored and reads 0.
- R8: Bit n of the pull-up word drives `pin_pullup[n]`.
- R9: A read of the plain, set or clear address of a register returns the register's current value on `bus_rdata` one clock after the read strobe. `bus_rdata` holds that value until the next read.
- R10: An access matches no register when its index is 7 or above, or when its view is 3. Such an access reads as 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: index, view, ignored low bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_func | output | 64 | Function code per pin, 2 bits each |
| pin_strength | output | 64 | Drive strength per pin, 2 bits each |
| pin_hv | output | 32 | Voltage select per pin |
| pin_pullup | output | 32 | Pull-up enable per pin |

## Verification
A write strobe sampled at one rising edge is visible on the pin vectors directly after that same edge. A read strobe sampled at an edge puts its data on `bus_rdata` directly after that edge. The bench therefore drives each access at a falling edge and updates its behavioural model at the next rising edge. It compares all pin vectors and `bus_rdata` against the model one nanosecond after that edge, on every clock. The directed checks on field isolation, reserved bits and unmapped addresses are taken at that same point.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_SET   = 2'd1,
    VIEW_CLR   = 2'd2,
    VIEW_NONE  = 2'd3
  } view_e;

  localparam int unsigned FUNC_W   = 2;
  localparam int unsigned DRV_W    = 4;
  localparam logic [3:0]  DRV_NIB_MASK = 4'h7;
endpackage

// File: rtl/padcfg_decode.sv
module padcfg_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [IDX_W-1:0]   idx,
  output padcfg_pkg::view_e  view,
  output logic               hit
);
  import padcfg_pkg::*;

  logic upper_zero;

  generate
    if (ADDR_W > IDX_W + 4) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:IDX_W+4] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign idx  = addr[IDX_W+3:4];
  assign view = view_e'(addr[3:2]);
  assign hit  = upper_zero && (32'(idx) < NUM_REGS) && (view != VIEW_NONE);
endmodule

// File: rtl/padcfg_reg.sv
module padcfg_reg #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      MASK = '1,
  parameter logic [W-1:0]      RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  padcfg_pkg::view_e view,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);
  import padcfg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= RST & MASK;
    end else if (wr_en) begin
      case (view)
        VIEW_PLAIN: q <= wdata & MASK;
        VIEW_SET:   q <= q | (wdata & MASK);
        VIEW_CLR:   q <= q & ~wdata;
        default:    q <= q;
      endcase
    end
  end

  AST_PLAIN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view == VIEW_PLAIN) |=> (q == ($past(wdata) & MASK))); // R2
  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view == VIEW_SET) |=> ((q & $past(q)) == $past(q))); // R3
  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view == VIEW_CLR) |=> ((q & $past(wdata)) == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R10
endmodule

// File: rtl/padcfg_regs.sv
module padcfg_regs #(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [1:0]  GPIO_CODE = 2'd3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [2*NUM_PINS-1:0] pin_func,
  output logic [2*NUM_PINS-1:0] pin_strength,
  output logic [NUM_PINS-1:0]   pin_hv,
  output logic [NUM_PINS-1:0]   pin_pullup
);
  import padcfg_pkg::*;

  localparam int unsigned PINS_PER_FUNC = DATA_W / FUNC_W;
  localparam int unsigned PINS_PER_DRV  = DATA_W / DRV_W;
  localparam int unsigned FUNC_REGS     = NUM_PINS / PINS_PER_FUNC;
  localparam int unsigned DRV_REGS      = NUM_PINS / PINS_PER_DRV;
  localparam int unsigned PULL_REGS     = NUM_PINS / DATA_W;
  localparam int unsigned DRV_BASE      = FUNC_REGS;
  localparam int unsigned PULL_BASE     = FUNC_REGS + DRV_REGS;
  localparam int unsigned NUM_REGS      = FUNC_REGS + DRV_REGS + PULL_REGS;
  localparam int unsigned IDX_W         = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] FUNC_RST = {PINS_PER_FUNC{GPIO_CODE}};
  localparam logic [DATA_W-1:0] DRV_MASK = {PINS_PER_DRV{DRV_NIB_MASK}};

  logic [IDX_W-1:0]  dec_idx;
  view_e             dec_view;
  logic              dec_hit;
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] rd_val;

  padcfg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr (bus_addr),
    .idx  (dec_idx),
    .view (dec_view),
    .hit  (dec_hit)
  );

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [DATA_W-1:0] R_MASK =
        (r >= DRV_BASE && r < PULL_BASE) ? DRV_MASK : {DATA_W{1'b1}};
      localparam logic [DATA_W-1:0] R_RST =
        (r < DRV_BASE) ? FUNC_RST : {DATA_W{1'b0}};
      logic wr_this;
      assign wr_this = bus_sel && bus_we && dec_hit && (32'(dec_idx) == r);
      padcfg_reg #(
        .W    (DATA_W),
        .MASK (R_MASK),
        .RST  (R_RST)
      ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_this),
        .view  (dec_view),
        .wdata (bus_wdata),
        .q     (regs_q[r])
      );
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int unsigned FR = p / PINS_PER_FUNC;
      localparam int unsigned FO = FUNC_W * (p % PINS_PER_FUNC);
      localparam int unsigned DR = DRV_BASE + p / PINS_PER_DRV;
      localparam int unsigned DO = DRV_W * (p % PINS_PER_DRV);
      localparam int unsigned PR = PULL_BASE + p / DATA_W;
      localparam int unsigned PO = p % DATA_W;
      assign pin_func[2*p +: 2]     = regs_q[FR][FO +: 2];
      assign pin_strength[2*p +: 2] = regs_q[DR][DO +: 2];
      assign pin_hv[p]              = regs_q[DR][DO + 2];
      assign pin_pullup[p]          = regs_q[PR][PO];
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (dec_hit && 32'(dec_idx) == r) rd_val = regs_q[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      bus_rdata <= rd_val;
    end
  end

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !dec_hit) |=>
      ($stable(pin_func) && $stable(pin_strength) && $stable(pin_hv) && $stable(pin_pullup))); // R10
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !dec_hit) |=> (bus_rdata == '0)); // R10
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/padcfg_regs_test.sv
module padcfg_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pin_func;
  logic [63:0] pin_strength;
  logic [31:0] pin_hv;
  logic [31:0] pin_pullup;

  int total = 0;
  int bad = 0;
  logic [31:0] mregs [7];
  logic [31:0] mrdata;

  always #2 clk = ~clk;

  padcfg_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_func(pin_func), .pin_strength(pin_strength),
    .pin_hv(pin_hv), .pin_pullup(pin_pullup)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mregs[0] = 32'hFFFF_FFFF;
    mregs[1] = 32'hFFFF_FFFF;
    for (int i = 2; i < 7; i++) mregs[i] = 32'h0;
    mrdata = 32'h0;
  endtask

  task automatic model_step(input logic we, input logic [7:0] a, input logic [31:0] d);
    int idx;
    int view;
    bit mapped;
    logic [31:0] mask;
    idx = int'(a[7:4]);
    view = int'(a[3:2]);
    mapped = (idx < 7) && (view != 3);
    mask = (idx >= 2 && idx <= 5) ? 32'h7777_7777 : 32'hFFFF_FFFF;
    if (we) begin
      if (mapped) begin
        if (view == 0) mregs[idx] = d & mask;
        else if (view == 1) mregs[idx] = mregs[idx] | (d & mask);
        else mregs[idx] = mregs[idx] & ~d;
      end
    end else begin
      mrdata = mapped ? mregs[idx] : 32'h0;
    end
  endtask

  task automatic compare_all();
    logic [63:0] ef;
    logic [63:0] es;
    logic [31:0] eh;
    for (int n = 0; n < 32; n++) begin
      ef[2*n +: 2] = mregs[n/16][2*(n%16) +: 2];
      es[2*n +: 2] = mregs[2 + n/8][4*(n%8) +: 2];
      eh[n]        = mregs[2 + n/8][4*(n%8) + 2];
    end
    chk(pin_func === ef, "R6 func map", pin_func, ef);
    chk(pin_strength === es, "R7 strength map", pin_strength, es);
    chk(pin_hv === eh, "R7 voltage map", {32'h0, pin_hv}, {32'h0, eh});
    chk(pin_pullup === mregs[6], "R8 pull map", {32'h0, pin_pullup}, {32'h0, mregs[6]});
    chk(bus_rdata === mrdata, "R9 readback", {32'h0, bus_rdata}, {32'h0, mrdata});
  endtask

  task automatic bus_op(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(we, a, d);
    #1;
    compare_all();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      compare_all();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] snap_f;
    logic [31:0] snap_p;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(pin_func === {64{1'b1}}, "R1 func GPIO", pin_func, {64{1'b1}});
    chk(pin_strength === 64'h0, "R1 strength", pin_strength, 64'h0);
    chk(pin_hv === 32'h0 && pin_pullup === 32'h0, "R1 hv/pull", {pin_hv, pin_pullup}, 64'h0);
    chk(bus_rdata === 32'h0, "R1 rdata", {32'h0, bus_rdata}, 64'h0);
    idle(2);

    // R2 plain write, R6 layout
    bus_op(1'b1, 8'h00, 32'h1234_5678);
    chk(pin_func[31:0] === 32'h1234_5678, "R2 plain write", {32'h0, pin_func[31:0]}, 64'h1234_5678);
    chk(pin_func[3:2] === 2'b10 && pin_func[33:32] === 2'b11, "R6 pin1/pin16", {60'h0, pin_func[33:32], pin_func[3:2]}, 64'hE);

    // R3 set, R4 clear on pull-up word
    bus_op(1'b1, 8'h60, 32'h8000_0000);
    bus_op(1'b1, 8'h64, 32'h0000_0001);
    chk(pin_pullup === 32'h8000_0001, "R3 set alias", {32'h0, pin_pullup}, 64'h8000_0001);
    bus_op(1'b1, 8'h68, 32'h8000_0000);
    chk(pin_pullup === 32'h0000_0001, "R4 clear alias", {32'h0, pin_pullup}, 64'h1);
    chk(pin_pullup[0] === 1'b1, "R8 pin0 pull", {63'h0, pin_pullup[0]}, 64'h1);

    // R7 reserved bit, R9 reads through every view
    bus_op(1'b1, 8'h20, 32'hFFFF_FFFF);
    bus_op(1'b0, 8'h20, 32'h0);
    chk(bus_rdata === 32'h7777_7777, "R7 reserved reads 0", {32'h0, bus_rdata}, 64'h7777_7777);
    bus_op(1'b0, 8'h64, 32'h0);
    chk(bus_rdata === 32'h0000_0001, "R9 read via set alias", {32'h0, bus_rdata}, 64'h1);
    bus_op(1'b0, 8'h28, 32'h0);
    chk(bus_rdata === 32'h7777_7777, "R9 read via clear alias", {32'h0, bus_rdata}, 64'h7777_7777);
    idle(2);
    chk(bus_rdata === 32'h7777_7777, "R9 rdata holds", {32'h0, bus_rdata}, 64'h7777_7777);

    // R5 clear-then-set on pin 2 drive nibble
    bus_op(1'b1, 8'h28, 32'h0000_0F00);
    bus_op(1'b1, 8'h24, 32'h0000_0500);
    chk(pin_strength[5:4] === 2'b01 && pin_hv[2] === 1'b1, "R5 field updated",
        {61'h0, pin_hv[2], pin_strength[5:4]}, 64'h5);
    chk(pin_strength[7:6] === 2'b11 && pin_strength[3:2] === 2'b11 && pin_hv[3] === 1'b1,
        "R5 neighbours kept", {59'h0, pin_hv[3], pin_strength[7:6], pin_strength[3:2]}, 64'h1F);

    // R10 unmapped accesses
    snap_f = pin_func;
    snap_p = pin_pullup;
    bus_op(1'b1, 8'h70, 32'hFFFF_FFFF);
    bus_op(1'b1, 8'h0C, 32'h0000_0000);
    bus_op(1'b1, 8'h80, 32'hFFFF_FFFF);
    chk(pin_func === snap_f && pin_pullup === snap_p, "R10 writes ignored", pin_func, snap_f);
    bus_op(1'b0, 8'h0C, 32'h0);
    chk(bus_rdata === 32'h0, "R10 view3 reads 0", {32'h0, bus_rdata}, 64'h0);
    bus_op(1'b0, 8'h70, 32'h0);
    chk(bus_rdata === 32'h0, "R10 index7 reads 0", {32'h0, bus_rdata}, 64'h0);

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      a = 8'(($urandom_range(0, 8) << 4) | ($urandom_range(0, 3) << 2));
      bus_op(1'($urandom_range(0, 1)), a, $urandom);
    end
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule